// File: doc/BRIEF.md
# Motor Step Detection Sequencer

This block runs the observation interval that follows a stepping-motor drive pulse. A start strobe arrives at the end of each drive pulse. The block then steers the bridge switches through three intervals in turn:

- a short interval, in which the winding is clamped through both high-side switches;
- a float interval, in which every switch it controls is open so that the winding inductance discharges;
- a sensing interval, in which a sample configuration is applied once per slot.

The sample configuration alternates from slot to slot between two arrangements. Each arrangement pairs one high-side switch with one sense switch. Which pairing belongs to which arrangement depends on the direction of the pulse just driven.

A digitised comparator reports the induced current at the end of each sample window. The block judges whether the rotor advanced and returns one pass/fail strobe to the pulse generator.

Time is counted in units of one period of the 32 kHz time base, and `UNIT_CYC` clock cycles make one unit. With the default values:

- clamp: 32 units (about 0.98 ms);
- float: 32 units;
- slot: 16 units (about 0.49 ms);
- sample window: the last 2 units of each slot (about 61 µs).

The whole interval lasts 896 units from the start strobe. This is the remainder of the 31.25 ms budget after a 3.9 ms drive pulse. Pulses of the strongest drive stage are flagged on `strongest_i` and are not observed.

Top module: `step_sense_seq`

## Requirements
- R1: After reset all four switch enables and `done_o` are low.
- R2: In units 0 to 31 after an accepted start, `hs_a_o` and `hs_b_o` are high and both sense enables are low.
- R3: In units 32 to 63 all four switch enables are low.
- R4: From unit 64, slots of 16 units are numbered from 0. Even slots are the forward-sense slots and odd slots are the reverse-sense slots. In the last 2 units of a slot the sense pattern is {`hs_a_o`,`hs_b_o`,`sense_a_o`,`sense_b_o`} = 0110 when (slot parity XOR `dir_i`) is 0, and 1001 when it is 1. In the other units of the slot the pattern is 1100.
- R5: The comparator is read only in the last unit of each slot. A high level at any other time has no effect.
- R6: A high read in an even slot is a positive detection, and a high read in an odd slot is a negative detection. The step passes when a negative detection comes no more than 128 + 32·`limit_i` units after the first positive detection. The strobe is raised in the cycle after that read.
- R7: Only the first positive detection starts the limit. A negative detection made before any positive one is ignored. A negative detection that comes too late does not produce a pass.
- R8: When no pass has occurred by unit 895, a failing strobe is given in the cycle after unit 895. Each accepted start gives exactly one strobe, one cycle long. After the strobe all switch enables are low.
- R9: A start with `strongest_i` high is not accepted. In that case no switch is enabled and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | one-cycle strobe at the end of a drive pulse |
| strongest_i | input | 1 | the pulse was of the strongest stage; skip detection |
| dir_i | input | 1 | polarity of the pulse just driven |
| limit_i | input | 3 | time-limit code, limit = 128 + 32·code units |
| cmp_i | input | 1 | digitised comparator level during a sample |
| hs_a_o | output | 1 | high-side switch, first motor terminal |
| hs_b_o | output | 1 | high-side switch, second motor terminal |
| sense_a_o | output | 1 | sense switch, first terminal |
| sense_b_o | output | 1 | sense switch, second terminal |
| done_o | output | 1 | one-cycle result strobe |
| pass_o | output | 1 | step result, valid with `done_o` |

## Verification
The switch enables decode the unit counter directly, so the pattern for unit c shows in the cycle that starts c edges after the start is captured. The bench predicts that pattern for every cycle of every run. A comparator read in unit E sets the strobe in cycle E+1, and a failure appears in cycle 896. The bench drives the comparator and compares the outputs on the falling clock edge, counting cycles from the capture edge. In this way each expected strobe cycle is derived from the requirements rather than from the design.

// File: rtl/step_sense_pkg.sv
package step_sense_pkg;
    typedef enum logic [1:0] {
        SW_OFF,
        SW_CLAMP,
        SW_FLOAT,
        SW_SAMPLE
    } sw_mode_e;
endpackage

// File: rtl/step_sense_tick.sv
module step_sense_tick #(
    parameter int UNIT_CYC = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == CW'(UNIT_CYC - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/step_sense_swmap.sv
module step_sense_swmap
    import step_sense_pkg::*;
(
    input  sw_mode_e mode_i,
    input  logic     odd_slot_i,
    input  logic     dir_i,
    output logic     hs_a_o,
    output logic     hs_b_o,
    output logic     sense_a_o,
    output logic     sense_b_o
);
    logic swap;
    assign swap = odd_slot_i ^ dir_i;

    always_comb begin
        hs_a_o    = 1'b0;
        hs_b_o    = 1'b0;
        sense_a_o = 1'b0;
        sense_b_o = 1'b0;
        unique case (mode_i)
            SW_CLAMP: begin
                hs_a_o = 1'b1;
                hs_b_o = 1'b1;
            end
            SW_SAMPLE: begin
                hs_a_o    = swap;
                sense_b_o = swap;
                hs_b_o    = !swap;
                sense_a_o = !swap;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/step_sense_seq.sv
module step_sense_seq
    import step_sense_pkg::*;
#(
    parameter int UNIT_CYC   = 1,
    parameter int CLAMP_U    = 32,
    parameter int FLOAT_U    = 32,
    parameter int SLOT_U     = 16,
    parameter int SAMP_U     = 2,
    parameter int LIM_BASE_U = 128,
    parameter int LIM_STEP_U = 32,
    parameter int DET_U      = 896
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       strongest_i,
    input  logic       dir_i,
    input  logic [2:0] limit_i,
    input  logic       cmp_i,
    output logic       hs_a_o,
    output logic       hs_b_o,
    output logic       sense_a_o,
    output logic       sense_b_o,
    output logic       done_o,
    output logic       pass_o
);
    localparam int SENSE_AT = CLAMP_U + FLOAT_U;
    localparam int EW       = $clog2(DET_U + 1);
    localparam int OW       = (SLOT_U > 1) ? $clog2(SLOT_U) : 1;

    typedef struct packed {
        logic          run;
        logic          dir;
        logic [EW-1:0] lim;
        logic [EW-1:0] unit;
        logic [OW-1:0] off;
        logic          odd;
        logic          pos_seen;
        logic [EW-1:0] pos_at;
        logic          done;
        logic          pass;
    } st_t;

    st_t      q, d;
    logic     tick, accept, in_sense, in_window, read_now, hit;
    sw_mode_e mode;
    logic     run_w;

    assign accept    = !q.run && start_i && !strongest_i;
    assign in_sense  = q.unit >= EW'(SENSE_AT);
    assign in_window = q.off >= OW'(SLOT_U - SAMP_U);
    assign read_now  = q.run && tick && in_sense && (q.off == OW'(SLOT_U - 1));
    assign run_w     = q.run;

    step_sense_tick #(.UNIT_CYC(UNIT_CYC)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (accept),
        .tick_o (tick)
    );

    always_comb begin
        if (!q.run)                          mode = SW_OFF;
        else if (q.unit < EW'(CLAMP_U))      mode = SW_CLAMP;
        else if (!in_sense)                  mode = SW_FLOAT;
        else if (in_window)                  mode = SW_SAMPLE;
        else                                 mode = SW_CLAMP;
    end

    step_sense_swmap u_map (
        .mode_i     (mode),
        .odd_slot_i (q.odd),
        .dir_i      (q.dir),
        .hs_a_o     (hs_a_o),
        .hs_b_o     (hs_b_o),
        .sense_a_o  (sense_a_o),
        .sense_b_o  (sense_b_o)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.pass = 1'b0;
        hit    = 1'b0;
        if (accept) begin
            d.run      = 1'b1;
            d.dir      = dir_i;
            d.lim      = EW'(LIM_BASE_U) + EW'(limit_i) * EW'(LIM_STEP_U);
            d.unit     = '0;
            d.off      = '0;
            d.odd      = 1'b0;
            d.pos_seen = 1'b0;
            d.pos_at   = '0;
        end else if (q.run && tick) begin
            d.unit = q.unit + 1'b1;
            if (in_sense) begin
                if (q.off == OW'(SLOT_U - 1)) begin
                    d.off = '0;
                    d.odd = !q.odd;
                end else begin
                    d.off = q.off + 1'b1;
                end
            end
            if (read_now && cmp_i) begin
                if (!q.odd && !q.pos_seen) begin
                    d.pos_seen = 1'b1;
                    d.pos_at   = q.unit;
                end
                if (q.odd && q.pos_seen && ((q.unit - q.pos_at) <= q.lim)) begin
                    hit = 1'b1;
                end
            end
            if (hit) begin
                d.run  = 1'b0;
                d.done = 1'b1;
                d.pass = 1'b1;
            end else if (q.unit == EW'(DET_U - 1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
                d.pass = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign done_o = q.done;
    assign pass_o = q.pass;
endmodule

// File: rtl/step_sense_chk.sv
module step_sense_chk #(
    parameter int UNIT_CYC = 1,
    parameter int DET_U    = 896
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic strongest_i,
    input logic run_i,
    input logic hs_a_o,
    input logic hs_b_o,
    input logic sense_a_o,
    input logic sense_b_o,
    input logic done_o
);
    localparam int MAXC = DET_U * UNIT_CYC + UNIT_CYC;

    int run_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      run_cnt_q <= 0;
        else if (!run_i)  run_cnt_q <= 0;
        else if (run_cnt_q < MAXC + 1) run_cnt_q <= run_cnt_q + 1;
    end

    a_r2_clamp_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> (hs_a_o && hs_b_o && !sense_a_o && !sense_b_o));

    a_r4_no_shoot_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sense_a_o |-> !hs_a_o);

    a_r4_no_shoot_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sense_b_o |-> !hs_b_o);

    a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r8_end_gives_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(run_i) |-> done_o);

    a_r8_bounded_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_cnt_q <= MAXC);

    a_r9_strongest_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && start_i && strongest_i) |=> !run_i);
endmodule

bind step_sense_seq step_sense_chk #(
    .UNIT_CYC (UNIT_CYC),
    .DET_U    (DET_U)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .strongest_i (strongest_i),
    .run_i       (run_w),
    .hs_a_o      (hs_a_o),
    .hs_b_o      (hs_b_o),
    .sense_a_o   (sense_a_o),
    .sense_b_o   (sense_b_o),
    .done_o      (done_o)
);

// File: tb/sim_step_sense_seq.sv
`timescale 1ns/1ps
module sim_step_sense_seq;
    localparam int DETU = 896;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, strongest = 1'b0, dir = 1'b0, cmp = 1'b0;
    logic [2:0] limit = '0;
    logic hs_a, hs_b, sa, sb, done, pass;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = !clk;

    step_sense_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .strongest_i(strongest),
        .dir_i(dir), .limit_i(limit), .cmp_i(cmp),
        .hs_a_o(hs_a), .hs_b_o(hs_b), .sense_a_o(sa), .sense_b_o(sb),
        .done_o(done), .pass_o(pass)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<190000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected {hs_a,hs_b,sense_a,sense_b} in unit c of a running phase
    function automatic int exp_sw(input int c, input logic d);
        int off, slot, sel;
        if (c < 32) return 4'b1100;
        if (c < 64) return 4'b0000;
        off  = (c - 64) % 16;
        slot = (c - 64) / 16;
        if (off < 14) return 4'b1100;
        sel = (slot & 1) ^ int'(d);
        return (sel == 0) ? 4'b0110 : 4'b1001;
    endfunction

    function automatic int rd_unit(input int slot);
        return 64 + 16 * slot + 15;
    endfunction

    // ps: first positive slot, p2: extra positive slot, ns: negative slot (-1: none)
    task automatic trial(input logic d, input int k, input int ps, input int p2,
                         input int ns, input bit early, input string req);
        int  ep, en, exp_c, got_c, strobes, slot, off, cur_sw;
        int  got_pass;
        bit  exp_pass;
        bit  sw_ok;
        ep = (ps >= 0) ? rd_unit(ps) : -1;
        en = (ns >= 0) ? rd_unit(ns) : -1;
        exp_pass = !early && ps >= 0 && ns >= 0 && en > ep && en < DETU && ep < DETU
                   && (en - ep) <= 128 + 32 * k;
        exp_c = exp_pass ? en + 1 : DETU;
        @(negedge clk);
        dir = d; limit = 3'(k); strongest = 1'b0; start = 1'b1; cmp = 1'b0;
        @(negedge clk);
        start = 1'b0;
        got_c = -1; got_pass = -1; strobes = 0; sw_ok = 1'b1;
        for (int c = 0; c < DETU + 8; c++) begin
            cur_sw = {hs_a, hs_b, sa, sb};
            if (cur_sw != ((c < exp_c) ? exp_sw(c, d) : 0)) begin
                if (sw_ok) chk("R2/R3/R4 switch pattern", cur_sw,
                               (c < exp_c) ? exp_sw(c, d) : 0);
                sw_ok = 1'b0;
            end
            if (done) begin
                strobes++;
                if (got_c < 0) begin got_c = c; got_pass = int'(pass); end
            end
            cmp = 1'b0;
            if (c >= 64) begin
                slot = (c - 64) / 16;
                off  = (c - 64) % 16;
                if ((slot == ps || slot == p2 || slot == ns) && (!early || off < 14))
                    cmp = 1'b1;
            end
            @(negedge clk);
        end
        cmp = 1'b0;
        if (sw_ok) chk("R2/R3/R4 switch pattern", 1, 1);
        chk({req, " strobe cycle"}, got_c, exp_c);
        chk({req, " result"}, got_pass, int'(exp_pass));
        chk("R8 one strobe", strobes, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset switches", {hs_a, hs_b, sa, sb}, 0);
        chk("R1 reset strobe", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 8; k++) begin
            trial(logic'(k & 1), k, 2, -1, 3, 1'b0, "R6 quick pass");
            trial(logic'(k & 1), k, 2, -1, 9 + 2 * k, 1'b0, "R6 pass at limit");
            trial(logic'(~k & 1), k, 2, -1, 11 + 2 * k, 1'b0, "R7 late negative");
        end
        trial(1'b0, 0, 2, -1, 1, 1'b0, "R7 negative first");
        trial(1'b1, 2, -1, -1, 5, 1'b0, "R7 negative only");
        trial(1'b0, 3, 4, -1, -1, 1'b0, "R8 positive only");
        trial(1'b1, 0, 2, 20, 21, 1'b0, "R7 first positive counts");
        trial(1'b0, 5, 2, -1, 3, 1'b1, "R5 outside sample window");
        trial(1'b1, 7, 30, -1, 51, 1'b0, "R6 pass in last read");
        trial(1'b0, 7, 32, -1, 53, 1'b0, "R8 negative past window");

        // R9: strongest-stage start is skipped
        @(negedge clk);
        strongest = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; strongest = 1'b0;
        begin
            int seen;
            int act_sw;
            seen = 0;
            act_sw = 0;
            for (int c = 0; c < 100; c++) begin
                if (done) seen++;
                act_sw = act_sw | {hs_a, hs_b, sa, sb};
                @(negedge clk);
            end
            chk("R9 no strobe", seen, 0);
            chk("R9 switches off", act_sw, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule